// File: doc/BRIEF.md
# Dual-Execution Reorder Buffer

This block is a circular reorder buffer that gives every instruction exactly one slot. It sends each arithmetic instruction to the execution units twice. The first result is kept in the slot. The second result is compared with it when it comes back. A match marks the slot finished. A mismatch sends the instruction back for a fresh pair of executions. Memory operations run once and are finished straight away. Finished slots leave the buffer strictly in program order, starting at the head.

Around the block, a decode stage pushes instructions on the allocation port. An operand tracker wakes slots whose inputs were not ready when they were allocated. A pool of execution units takes work from the issue port and returns results on the writeback port. The commit stage drains the retire port. A branch or exception unit can cut away every slot younger than a given slot.

Handshake rules are as follows. A transfer happens on any cycle where valid and ready are both high. Once retire_valid is up, its index, op and data hold until retire_ready is taken. On the issue port the offer is re-evaluated every cycle. A higher-priority candidate can replace the current offer while issue_ready is low. Allocation and issue are held off in a cycle with a flush. Writeback has no back-pressure.

Top module: `dual_exec_rob`

## Requirements
- R1: Each accepted allocation takes the single slot at the tail, reported on alloc_idx, and advances the tail by one. alloc_ready is low while all DEPTH slots are occupied.
- R2: A slot allocated with alloc_src_ok low is not offered for issue until wake_valid names it.
- R3: A non-memory slot is issued first with issue_second=0 and then with issue_second=1. Matching results make it retirable, with the first result as ret_data.
- R4: When the second result differs from the first, the slot returns to first-execution readiness. It is then issued twice more before it can retire.
- R5: A slot allocated with alloc_mem high is issued once and is retirable with that single result.
- R6: Slots awaiting their second execution are offered before slots awaiting their first. Within each group, the slot nearest the head wins.
- R7: Retirement takes only the head slot, once it is finished. A finished younger slot waits behind an unfinished head. Consecutive finished slots retire on back-to-back cycles.
- R8: A flush naming an occupied slot discards every younger slot and keeps that slot and all older ones. The next allocation then lands at flush_idx+1.
- R9: err_flag rises once a slot has seen MISS_LIMIT (default 3) disagreements. It falls when that slot leaves the buffer.
- R10: While retire_valid is high and retire_ready low, the retire offer and its payload stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | New instruction offered |
| alloc_ready | output | 1 | A slot is free and no flush is active |
| alloc_mem | input | 1 | Instruction is a load or store |
| alloc_src_ok | input | 1 | Operands already available |
| alloc_op | input | OPW | Opaque operation tag |
| alloc_idx | output | IW | Slot the next allocation takes |
| wake_valid | input | 1 | Operands of a waiting slot became available |
| wake_idx | input | IW | Slot being woken |
| issue_valid | output | 1 | An execution is offered |
| issue_ready | input | 1 | Execution units accept the offer |
| issue_idx | output | IW | Slot being issued |
| issue_second | output | 1 | 1 for the checking execution |
| issue_op | output | OPW | Operation tag of the offered slot |
| wb_valid | input | 1 | Result returned |
| wb_idx | input | IW | Slot the result belongs to |
| wb_data | input | DW | Result value |
| ret_valid | output | 1 | Head slot is finished |
| ret_ready | input | 1 | Commit stage takes the head |
| ret_idx | output | IW | Slot being retired |
| ret_op | output | OPW | Operation tag of the retired slot |
| ret_data | output | DW | Verified result |
| flush_valid | input | 1 | Discard slots younger than flush_idx |
| flush_idx | input | IW | Youngest slot to keep |
| err_flag | output | 1 | Some slot reached the disagreement limit |

## Verification
A corrupted slot state shows up at the ports within a cycle or two. A slot stuck before its second execution leaves issue_second low where a checking execution is due. A slot wrongly marked finished raises ret_valid, and ret_data then carries an unchecked value. A bad head or tail pointer shows directly in alloc_idx or ret_idx. It also makes alloc_ready drop at the wrong occupancy, visible the cycle after the offending allocation or flush. A lost mismatch count shows as err_flag staying low after the third disagreement, observed the cycle after that writeback.

// File: rtl/drob_pkg.sv
`timescale 1ns/1ps
package drob_pkg;
  typedef enum logic [2:0] {
    ST_EMPTY = 3'd0,
    ST_WAIT  = 3'd1,
    ST_RDY1  = 3'd2,
    ST_RDY2  = 3'd3,
    ST_DONE  = 3'd4
  } ent_state_t;
endpackage

// File: rtl/drob_entry.sv
`timescale 1ns/1ps
module drob_entry
  import drob_pkg::*;
#(
  parameter int DW         = 16,
  parameter int OPW        = 8,
  parameter int MISS_LIMIT = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_i,
  input  logic           alloc_mem_i,
  input  logic           alloc_rdy_i,
  input  logic [OPW-1:0] alloc_op_i,
  input  logic           wake_i,
  input  logic           issue_i,
  input  logic           wb_i,
  input  logic [DW-1:0]  wb_data_i,
  input  logic           retire_i,
  input  logic           kill_i,
  output ent_state_t     state_o,
  output logic           busy_o,
  output logic [OPW-1:0] op_o,
  output logic [DW-1:0]  res_o,
  output logic           err_o
);
  localparam int CW = $clog2(MISS_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(MISS_LIMIT);

  ent_state_t     state_q;
  logic           busy_q;
  logic           mem_q;
  logic [OPW-1:0] op_q;
  logic [DW-1:0]  res_q;
  logic [CW-1:0]  miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_EMPTY;
      busy_q  <= 1'b0;
      mem_q   <= 1'b0;
      op_q    <= '0;
      res_q   <= '0;
      miss_q  <= '0;
    end else if (kill_i || retire_i) begin
      state_q <= ST_EMPTY;
      busy_q  <= 1'b0;
      miss_q  <= '0;
    end else if (alloc_i) begin
      state_q <= alloc_rdy_i ? ST_RDY1 : ST_WAIT;
      busy_q  <= 1'b0;
      mem_q   <= alloc_mem_i;
      op_q    <= alloc_op_i;
      miss_q  <= '0;
    end else begin
      if (wake_i && state_q == ST_WAIT) state_q <= ST_RDY1;
      if (issue_i) busy_q <= 1'b1;
      if (wb_i && busy_q) begin
        busy_q <= 1'b0;
        case (state_q)
          ST_RDY1: begin
            res_q   <= wb_data_i;
            state_q <= mem_q ? ST_DONE : ST_RDY2;
          end
          ST_RDY2: begin
            if (wb_data_i == res_q) begin
              state_q <= ST_DONE;
            end else begin
              state_q <= ST_RDY1;
              if (miss_q != LIM) miss_q <= miss_q + CW'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign busy_o  = busy_q;
  assign op_o    = op_q;
  assign res_o   = res_q;
  assign err_o   = (miss_q == LIM);
endmodule

// File: rtl/drob_pick.sv
`timescale 1ns/1ps
module drob_pick #(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic [DEPTH-1:0] cand_i,
  input  logic [IW-1:0]    base_i,
  output logic             any_o,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (cand_i[base_i + IW'(k)]) begin
        any_o = 1'b1;
        idx_o = base_i + IW'(k);
      end
    end
  end
endmodule

// File: rtl/drob_ptrs.sv
`timescale 1ns/1ps
module drob_ptrs #(
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          cut_i,
  input  logic [IW-1:0] cut_age_i,
  output logic [IW-1:0] head_o,
  output logic [IW-1:0] tail_o,
  output logic [IW:0]   count_o,
  output logic          full_o
);
  logic [IW:0] head_q, tail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (pop_i) head_q <= head_q + (IW+1)'(1);
      if (cut_i)       tail_q <= head_q + {1'b0, cut_age_i} + (IW+1)'(1);
      else if (push_i) tail_q <= tail_q + (IW+1)'(1);
    end
  end

  assign head_o  = head_q[IW-1:0];
  assign tail_o  = tail_q[IW-1:0];
  assign count_o = tail_q - head_q;
  assign full_o  = (count_o == (IW+1)'(DEPTH));
endmodule

// File: rtl/dual_exec_rob.sv
`timescale 1ns/1ps
module dual_exec_rob
  import drob_pkg::*;
#(
  parameter  int DEPTH      = 8,
  parameter  int DW         = 16,
  parameter  int OPW        = 8,
  parameter  int MISS_LIMIT = 3,
  localparam int IW         = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_valid,
  output logic           alloc_ready,
  input  logic           alloc_mem,
  input  logic           alloc_src_ok,
  input  logic [OPW-1:0] alloc_op,
  output logic [IW-1:0]  alloc_idx,
  input  logic           wake_valid,
  input  logic [IW-1:0]  wake_idx,
  output logic           issue_valid,
  input  logic           issue_ready,
  output logic [IW-1:0]  issue_idx,
  output logic           issue_second,
  output logic [OPW-1:0] issue_op,
  input  logic           wb_valid,
  input  logic [IW-1:0]  wb_idx,
  input  logic [DW-1:0]  wb_data,
  output logic           ret_valid,
  input  logic           ret_ready,
  output logic [IW-1:0]  ret_idx,
  output logic [OPW-1:0] ret_op,
  output logic [DW-1:0]  ret_data,
  input  logic           flush_valid,
  input  logic [IW-1:0]  flush_idx,
  output logic           err_flag
);
  ent_state_t     st   [DEPTH];
  logic [OPW-1:0] opa  [DEPTH];
  logic [DW-1:0]  res  [DEPTH];
  logic [DEPTH-1:0] busy, errv, kill, sec_c, fst_c;

  logic [IW-1:0] head_idx, tail_idx, flush_age, sec_idx, fst_idx;
  logic [IW:0]   count;
  logic          full, flush_ok, sec_any, fst_any;
  logic          alloc_fire, iss_fire, ret_fire;

  assign flush_age = flush_idx - head_idx;
  assign flush_ok  = flush_valid && ({1'b0, flush_age} < count);

  assign alloc_ready = !full && !flush_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_idx   = tail_idx;

  drob_ptrs #(.DEPTH(DEPTH), .IW(IW)) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .push_i(alloc_fire), .pop_i(ret_fire),
    .cut_i(flush_ok), .cut_age_i(flush_age),
    .head_o(head_idx), .tail_o(tail_idx),
    .count_o(count), .full_o(full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [IW-1:0] age;
    assign age     = IW'(i) - head_idx;
    assign kill[i] = flush_ok && (age > flush_age) && ({1'b0, age} < count);
    assign sec_c[i] = (st[i] == ST_RDY2) && !busy[i];
    assign fst_c[i] = (st[i] == ST_RDY1) && !busy[i];

    drob_entry #(.DW(DW), .OPW(OPW), .MISS_LIMIT(MISS_LIMIT)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (alloc_fire && tail_idx == IW'(i)),
      .alloc_mem_i(alloc_mem),
      .alloc_rdy_i(alloc_src_ok),
      .alloc_op_i (alloc_op),
      .wake_i     (wake_valid && wake_idx == IW'(i)),
      .issue_i    (iss_fire && issue_idx == IW'(i)),
      .wb_i       (wb_valid && wb_idx == IW'(i)),
      .wb_data_i  (wb_data),
      .retire_i   (ret_fire && head_idx == IW'(i)),
      .kill_i     (kill[i]),
      .state_o    (st[i]),
      .busy_o     (busy[i]),
      .op_o       (opa[i]),
      .res_o      (res[i]),
      .err_o      (errv[i])
    );
  end

  drob_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick_sec (
    .cand_i(sec_c), .base_i(head_idx), .any_o(sec_any), .idx_o(sec_idx)
  );
  drob_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick_fst (
    .cand_i(fst_c), .base_i(head_idx), .any_o(fst_any), .idx_o(fst_idx)
  );

  assign issue_valid  = (sec_any || fst_any) && !flush_valid;
  assign issue_second = sec_any;
  assign issue_idx    = sec_any ? sec_idx : fst_idx;
  assign issue_op     = opa[issue_idx];
  assign iss_fire     = issue_valid && issue_ready;

  assign ret_valid = (st[head_idx] == ST_DONE);
  assign ret_idx   = head_idx;
  assign ret_op    = opa[head_idx];
  assign ret_data  = res[head_idx];
  assign ret_fire  = ret_valid && ret_ready;

  assign err_flag = |errv;
endmodule

// File: rtl/drob_chk.sv
`timescale 1ns/1ps
module drob_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  parameter int OPW   = 8,
  parameter int IW    = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [IW:0]    count,
  input logic           alloc_valid,
  input logic           alloc_ready,
  input logic           ret_valid,
  input logic           ret_ready,
  input logic [OPW-1:0] ret_op,
  input logic [DW-1:0]  ret_data,
  input logic           flush_ok,
  input logic [IW-1:0]  flush_age,
  input logic           err_flag
);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (IW+1)'(DEPTH));

  assert_alloc_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_ready && !(ret_valid && ret_ready) && !flush_ok
    |=> count == $past(count) + (IW+1)'(1));

  assert_ret_shrinks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && ret_ready && !(alloc_valid && alloc_ready) && !flush_ok
    |=> count == $past(count) - (IW+1)'(1));

  assert_flush_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_ok && !(ret_valid && ret_ready)
    |=> count == {1'b0, $past(flush_age)} + (IW+1)'(1));

  assert_ret_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !ret_ready |=> ret_valid && $stable(ret_data) && $stable(ret_op));

  assert_err_occupied_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> count != '0);
endmodule

bind dual_exec_rob drob_chk #(.DEPTH(DEPTH), .DW(DW), .OPW(OPW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count),
  .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .ret_valid(ret_valid), .ret_ready(ret_ready),
  .ret_op(ret_op), .ret_data(ret_data),
  .flush_ok(flush_ok), .flush_age(flush_age), .err_flag(err_flag)
);

// File: tb/tb_dual_exec_rob.sv
`timescale 1ns/1ps
module tb_dual_exec_rob;
  localparam int DEPTH = 8;
  localparam int DW    = 16;
  localparam int OPW   = 8;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, alloc_mem = 0, alloc_src_ok = 0;
  logic [OPW-1:0] alloc_op = '0;
  logic alloc_ready;
  logic [IW-1:0] alloc_idx;
  logic wake_valid = 0;
  logic [IW-1:0] wake_idx = '0;
  logic issue_valid, issue_second;
  logic issue_ready = 0;
  logic [IW-1:0] issue_idx;
  logic [OPW-1:0] issue_op;
  logic wb_valid = 0;
  logic [IW-1:0] wb_idx = '0;
  logic [DW-1:0] wb_data = '0;
  logic ret_valid;
  logic ret_ready = 0;
  logic [IW-1:0] ret_idx;
  logic [OPW-1:0] ret_op;
  logic [DW-1:0] ret_data;
  logic flush_valid = 0;
  logic [IW-1:0] flush_idx = '0;
  logic err_flag;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dual_exec_rob #(.DEPTH(DEPTH), .DW(DW), .OPW(OPW), .MISS_LIMIT(3)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_mem(alloc_mem),
    .alloc_src_ok(alloc_src_ok), .alloc_op(alloc_op), .alloc_idx(alloc_idx),
    .wake_valid(wake_valid), .wake_idx(wake_idx),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_idx(issue_idx),
    .issue_second(issue_second), .issue_op(issue_op),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_idx(ret_idx),
    .ret_op(ret_op), .ret_data(ret_data),
    .flush_valid(flush_valid), .flush_idx(flush_idx), .err_flag(err_flag)
  );

  typedef struct packed {
    logic          mem;
    logic [7:0]    op;
    logic [15:0]   v0, v1, v2, v3;
  } vec_t;

  localparam vec_t TAB [6] = '{
    '{1'b1, 8'h10, 16'h1234, 16'h0000, 16'h0000, 16'h0000},
    '{1'b0, 8'h21, 16'hAAAA, 16'hAAAA, 16'h0000, 16'h0000},
    '{1'b0, 8'h32, 16'h0F0F, 16'h0F0E, 16'h0F0F, 16'h0F0F},
    '{1'b1, 8'h43, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000},
    '{1'b0, 8'h54, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{1'b0, 8'h65, 16'h8000, 16'h0001, 16'h7777, 16'h7777}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic alloc1(input bit mem, input bit ok, input logic [OPW-1:0] op);
    @(negedge clk);
    alloc_valid = 1; alloc_mem = mem; alloc_src_ok = ok; alloc_op = op;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic wake1(input int idx);
    @(negedge clk);
    wake_valid = 1; wake_idx = IW'(idx);
    @(negedge clk);
    wake_valid = 0;
  endtask

  task automatic exec(input int idx, input bit sec, input logic [DW-1:0] d,
                      input string req);
    @(negedge clk);
    chk(issue_valid && issue_idx == IW'(idx) && issue_second == sec, req,
        "issue {valid,second,idx}", {issue_valid, issue_second, issue_idx},
        {1'b1, sec, IW'(idx)});
    issue_ready = 1;
    @(negedge clk);
    issue_ready = 0;
    wb_valid = 1; wb_idx = IW'(idx); wb_data = d;
    @(negedge clk);
    wb_valid = 0;
  endtask

  task automatic run_one(input vec_t v);
    logic [DW-1:0] vs [4];
    int n;
    int exp_n;
    logic [DW-1:0] exp_d;
    bit done;
    vs[0] = v.v0; vs[1] = v.v1; vs[2] = v.v2; vs[3] = v.v3;
    exp_n = v.mem ? 1 : ((v.v0 == v.v1) ? 2 : 4);
    exp_d = (v.mem || v.v0 == v.v1) ? v.v0 : v.v2;
    n = 0;
    done = 0;
    @(negedge clk);
    chk(alloc_ready, "R1", "alloc_ready", alloc_ready, 1);
    alloc_valid = 1; alloc_mem = v.mem; alloc_src_ok = 1; alloc_op = v.op;
    @(negedge clk);
    alloc_valid = 0;
    for (int it = 0; it < 30 && !done; it++) begin
      if (ret_valid) begin
        chk(ret_data == exp_d && ret_op == v.op, v.mem ? "R5" : (exp_n == 4 ? "R4" : "R3"),
            "ret_data", ret_data, exp_d);
        chk(n == exp_n, v.mem ? "R5" : (exp_n == 4 ? "R4" : "R3"),
            "execution count", n, exp_n);
        ret_ready = 1;
        @(negedge clk);
        ret_ready = 0;
        done = 1;
      end else if (issue_valid) begin
        chk(issue_second == (!v.mem && n[0]), "R3", "issue_second",
            issue_second, (!v.mem && n[0]));
        issue_ready = 1;
        wb_idx = issue_idx;
        @(negedge clk);
        issue_ready = 0;
        wb_valid = 1; wb_data = vs[n % 4];
        n++;
        @(negedge clk);
        wb_valid = 0;
      end else begin
        @(negedge clk);
      end
    end
    chk(done, "R7", "instruction retired", done, 1);
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk(alloc_ready && !issue_valid && !ret_valid && !err_flag && alloc_idx == 0,
        "R1", "reset state", {alloc_ready, issue_valid, ret_valid, err_flag}, 4'b1000);

    for (int pass = 0; pass < 2; pass++)
      for (int k = 0; k < 6; k++) run_one(TAB[k]);

    do_reset();
    for (int k = 0; k < DEPTH; k++) alloc1(1'b0, 1'b0, OPW'(k));
    @(negedge clk);
    chk(!alloc_ready, "R1", "alloc_ready when full", alloc_ready, 0);
    chk(!issue_valid, "R2", "waiting slots not issued", issue_valid, 0);

    @(negedge clk);
    flush_valid = 1; flush_idx = 3'd3;
    @(negedge clk);
    flush_valid = 0;
    #1;
    chk(alloc_ready && alloc_idx == 3'd4, "R8", "tail after flush",
        {alloc_ready, alloc_idx}, {1'b1, 3'd4});

    wake1(2);
    exec(2, 0, 16'h0055, "R2");
    wake1(1);
    exec(2, 1, 16'h0055, "R6");
    @(negedge clk);
    chk(!ret_valid, "R7", "younger done slot blocked by head", ret_valid, 0);
    exec(1, 0, 16'h0011, "R6");
    wake1(0);
    exec(1, 1, 16'h0012, "R6");
    exec(0, 0, 16'h0007, "R4");
    exec(0, 1, 16'h0007, "R6");
    @(negedge clk);
    chk(ret_valid && ret_idx == 0 && ret_data == 16'h0007, "R7", "head retire offer",
        ret_data, 16'h0007);
    @(negedge clk);
    chk(ret_valid && ret_idx == 0 && ret_data == 16'h0007 && ret_op == 8'h00, "R10",
        "retire offer held", ret_data, 16'h0007);
    ret_ready = 1;
    @(negedge clk);
    ret_ready = 0;

    exec(1, 0, 16'h0001, "R4");
    exec(1, 1, 16'h0002, "R4");
    @(negedge clk);
    chk(!err_flag, "R9", "err_flag below limit", err_flag, 0);
    exec(1, 0, 16'h0003, "R4");
    exec(1, 1, 16'h0004, "R4");
    @(negedge clk);
    chk(err_flag, "R9", "err_flag at limit", err_flag, 1);
    exec(1, 0, 16'h0009, "R4");
    exec(1, 1, 16'h0009, "R3");

    @(negedge clk);
    chk(ret_valid && ret_idx == 1 && ret_data == 16'h0009, "R7", "run first",
        ret_data, 16'h0009);
    ret_ready = 1;
    @(negedge clk);
    chk(ret_valid && ret_idx == 2 && ret_data == 16'h0055, "R7", "run back-to-back",
        ret_data, 16'h0055);
    @(negedge clk);
    ret_ready = 0;
    #1;
    chk(!ret_valid, "R7", "waiting head stops run", ret_valid, 0);
    chk(!err_flag, "R9", "err_flag clears after retire", err_flag, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule